// File: doc/BRIEF.md
# Per-Bank Open Row Tracker

This block keeps a record of the row that is currently open in each bank of a single-rank DDR2 device with four banks. A memory scheduler gives it a bank index and a row address. In the same cycle the block reports one of three results. The access can hit the open row. It can conflict with a different open row. Or the bank can be idle, which raises neither output. The scheduler uses this result to decide whether the access can go straight to a column command, needs a precharge and an activate first, or needs only an activate.

The scheduler reports its own commands back to the block. An activate of a bank stores the new row and marks the bank open. A precharge of a single bank marks that bank closed. A precharge of all banks, or a refresh, closes all four banks at one clock edge. The stored rows are read combinationally, so lookups need no pipeline stage. The bank state changes at the clock edge that follows a command.

Top module: `open_row_tracker`

## Requirements
- R1: After a synchronous active-low reset, `hit` and `conflict` are both 0 for every bank and every row until that bank is activated.
- R2: In the cycle after `act_en` is high with no clear pending, presenting the same bank and row gives `hit`=1 and `conflict`=0.
- R3: For an open bank, presenting a row that differs from the stored row gives `conflict`=1 and `hit`=0.
- R4: For a bank that has never been activated, or has been closed, `hit` and `conflict` are both 0, whatever the row.
- R5: Activating one bank does not change the open or closed state, or the stored row, of any other bank.
- R6: `close_one` high closes only the bank selected by `bank_sel` from the next cycle onward. The other banks keep their rows and their open state.
- R7: `close_all` high closes all four banks from the next cycle onward.
- R8: `hit` and `conflict` are combinational in `bank_sel` and `row_addr`. They reflect the state that existed before the current cycle's command takes effect.
- R9: When `act_en` coincides with `close_one` on the same bank, or with `close_all`, the close wins and the bank is left closed.
- R10: Activating an already open bank replaces its stored row. The old row then reports a conflict.
- R11: `hit` and `conflict` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; closes all banks |
| bank_sel | input | 2 | Bank index for lookup and for activate or close_one |
| row_addr | input | 13 | Row address to compare, and the row stored on activate |
| act_en | input | 1 | Activate: store `row_addr` at `bank_sel` and mark the bank open |
| close_one | input | 1 | Precharge of the bank at `bank_sel`: mark it closed |
| close_all | input | 1 | Precharge-all or refresh: mark every bank closed |
| hit | output | 1 | Selected bank is open and its stored row equals `row_addr` |
| conflict | output | 1 | Selected bank is open and its stored row differs from `row_addr` |

## Verification
Lookups are tried in four ways: against an idle bank, against the matching row, against a row one bit away, and against a row in a bank next to a recently activated one. Together these separate a missing valid gate, a faulty comparator and a wrong bank index. The bench then replaces the row of an open bank and closes banks one at a time, which shows whether a clear reaches only its own bank. It also closes all banks at once. Activates that coincide with each kind of close, followed by a reset taken in mid-run, fix the precedence between commands and show that reset clears the open state.

// File: rtl/ort_pkg.sv
// Package: shared sizing for the open row tracker.
// Assumes a single rank; bank count must be a power of two.
package ort_pkg;
    parameter int ORT_NUM_BANKS = 4;
    parameter int ORT_ROW_W     = 13;
endpackage

// File: rtl/ort_row_store.sv
// Row store: one row address register per bank, written on activate,
// read combinationally at the lookup index.
// Assumes contents of a closed bank are never used (gated by valid).
module ort_row_store #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] idx,
    input  logic [ROW_W-1:0]  wr_row,
    output logic [ROW_W-1:0]  rd_row
);
    logic [ROW_W-1:0] rows_q [NUM_BANKS];

    // Capture the activated row at its bank slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows_q[idx] <= wr_row;
        end
    end

    // Asynchronous read of the selected slot.
    always_comb begin
        rd_row = rows_q[idx];
    end
endmodule

// File: rtl/ort_valid_bits.sv
// Valid bits: one flop per bank marking an open row.
// Precedence per bank: reset, close-all, close-one, then activate.
module ort_valid_bits #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_W-1:0]    idx,
    input  logic                 set_en,
    input  logic                 clr_one,
    input  logic                 clr_all,
    output logic [NUM_BANKS-1:0] open_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (idx == BANK_W'(b));

        // Update this bank's open flag from the command inputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
            end else if (clr_all) begin
                open_q[b] <= 1'b0;
            end else if (sel && clr_one) begin
                open_q[b] <= 1'b0;
            end else if (sel && set_en) begin
                open_q[b] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ort_match.sv
// Match: compares the stored and incoming row once and splits the
// result into hit and conflict, both gated by the bank's open flag.
module ort_match #(
    parameter int ROW_W = 13
) (
    input  logic             bank_open,
    input  logic [ROW_W-1:0] stored_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             hit,
    output logic             conflict
);
    logic same;

    // Single equality compare shared by both outputs.
    always_comb begin
        same     = (stored_row == req_row);
        hit      = bank_open & same;
        conflict = bank_open & ~same;
    end
endmodule

// File: rtl/open_row_tracker.sv
// Top: tracks the open row of each bank of a single-rank device and
// reports hit or conflict for the presented bank/row in the same cycle.
// Assumes commands arrive at most one per cycle on the shared bank index.
module open_row_tracker #(
    parameter int NUM_BANKS = ort_pkg::ORT_NUM_BANKS,
    parameter int ROW_W     = ort_pkg::ORT_ROW_W,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic              act_en,
    input  logic              close_one,
    input  logic              close_all,
    output logic              hit,
    output logic              conflict
);
    logic [ROW_W-1:0]     stored_row;
    logic [NUM_BANKS-1:0] open_q;

    ort_row_store #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_store (
        .clk    (clk),
        .wr_en  (act_en),
        .idx    (bank_sel),
        .wr_row (row_addr),
        .rd_row (stored_row)
    );

    ort_valid_bits #(.NUM_BANKS(NUM_BANKS)) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (bank_sel),
        .set_en  (act_en),
        .clr_one (close_one),
        .clr_all (close_all),
        .open_q  (open_q)
    );

    ort_match #(.ROW_W(ROW_W)) u_match (
        .bank_open  (open_q[bank_sel]),
        .stored_row (stored_row),
        .req_row    (row_addr),
        .hit        (hit),
        .conflict   (conflict)
    );
endmodule

// File: rtl/ort_checker.sv
// Checker: temporal properties of the tracker seen at its ports.
module ort_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BANK_W-1:0] bank_sel,
    input logic [ROW_W-1:0]  row_addr,
    input logic              act_en,
    input logic              close_one,
    input logic              close_all,
    input logic              hit,
    input logic              conflict
);
    // R11
    exclusive_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && conflict));

    // R7
    close_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_all |=> (!hit && !conflict));

    // R2
    activate_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !close_one && !close_all) |=>
            (!($stable(bank_sel) && $stable(row_addr)) || hit));

    // R3
    activate_then_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !close_one && !close_all) |=>
            (!($stable(bank_sel) && !$stable(row_addr)) || conflict));

    // R6
    close_one_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_one |=> (!$stable(bank_sel) || (!hit && !conflict)));
endmodule

bind open_row_tracker ort_checker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/open_row_tracker_test.sv
module open_row_tracker_test;
    localparam int NV = 24;
    // {act, close_one, close_all, bank[1:0], row[12:0], exp_hit, exp_conf}
    typedef logic [19:0] vec_t;

    function automatic vec_t mk(input logic a, input logic c1, input logic ca,
                                input logic [1:0] b, input logic [12:0] r,
                                input logic eh, input logic ec);
        return {a, c1, ca, b, r, eh, ec};
    endfunction

    localparam vec_t VEC [NV] = '{
        mk(0,0,0,2'd0,13'h0100,0,0),  // 0  R1 idle after reset
        mk(1,0,0,2'd0,13'h0100,0,0),  // 1  R4 activate, still closed this cycle
        mk(0,0,0,2'd0,13'h0100,1,0),  // 2  R2
        mk(0,0,0,2'd0,13'h0101,0,1),  // 3  R3 one bit off
        mk(0,0,0,2'd1,13'h0100,0,0),  // 4  R5 neighbour idle
        mk(1,0,0,2'd3,13'h1FFF,0,0),  // 5  R4
        mk(0,0,0,2'd3,13'h1FFF,1,0),  // 6  R2
        mk(0,0,0,2'd0,13'h0100,1,0),  // 7  R5 bank0 unchanged
        mk(1,0,0,2'd0,13'h00AA,0,1),  // 8  R8 old state seen
        mk(0,0,0,2'd0,13'h00AA,1,0),  // 9  R10
        mk(0,0,0,2'd0,13'h0100,0,1),  // 10 R10 old row conflicts
        mk(0,1,0,2'd0,13'h00AA,1,0),  // 11 R8 close pending
        mk(0,0,0,2'd0,13'h00AA,0,0),  // 12 R6
        mk(0,0,0,2'd3,13'h1FFF,1,0),  // 13 R6 other bank kept
        mk(1,0,0,2'd1,13'h0555,0,0),  // 14 R4
        mk(1,0,0,2'd2,13'h0000,0,0),  // 15 R4
        mk(0,0,1,2'd1,13'h0555,1,0),  // 16 R8 close_all pending
        mk(0,0,0,2'd1,13'h0555,0,0),  // 17 R7
        mk(0,0,0,2'd2,13'h0000,0,0),  // 18 R7
        mk(0,0,0,2'd3,13'h1FFF,0,0),  // 19 R7
        mk(1,1,0,2'd2,13'h0077,0,0),  // 20 R9 act with close_one
        mk(0,0,0,2'd2,13'h0077,0,0),  // 21 R9
        mk(1,0,1,2'd1,13'h0010,0,0),  // 22 R9 act with close_all
        mk(0,0,0,2'd1,13'h0010,0,0)   // 23 R9
    };

    function automatic string req_of(input int i);
        case (i)
            0: return "R1";
            1, 5, 14, 15: return "R4";
            2, 6: return "R2";
            3: return "R3";
            4, 7: return "R5";
            8, 11, 16: return "R8";
            9, 10: return "R10";
            12, 13: return "R6";
            17, 18, 19: return "R7";
            default: return "R9";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bank_sel;
    logic [12:0] row_addr;
    logic        act_en, close_one, close_all;
    logic        hit, conflict;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    open_row_tracker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_sel  (bank_sel),
        .row_addr  (row_addr),
        .act_en    (act_en),
        .close_one (close_one),
        .close_all (close_all),
        .hit       (hit),
        .conflict  (conflict)
    );

    task automatic check(input string req, input logic eh, input logic ec);
        n_chk++;
        if (hit !== eh || conflict !== ec) begin
            n_bad++;
            $display("FAIL %s: hit/conflict = %b%b, expected %b%b", req, hit, conflict, eh, ec);
        end
        n_chk++;
        if (hit && conflict) begin
            n_bad++;
            $display("FAIL R11: hit/conflict = 11, expected not both");
        end
    endtask

    task automatic drive(input logic a, input logic c1, input logic ca,
                         input logic [1:0] b, input logic [12:0] r);
        act_en = a; close_one = c1; close_all = ca; bank_sel = b; row_addr = r;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 2'd0, 13'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at negedge, sample 1 ns later (before posedge).
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:15], VEC[i][14:2]);
            #1;
            check(req_of(i), VEC[i][1], VEC[i][0]);
            @(negedge clk);
        end

        // R1: every bank idle after reset, whatever the row.
        drive(1, 0, 0, 2'd2, 13'h0042);
        @(negedge clk);
        drive(0, 0, 0, 2'd2, 13'h0042);
        #1; check("R2", 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 4; b++) begin
            drive(0, 0, 0, 2'(b), 13'h0042);
            #1; check("R1", 1'b0, 1'b0);
        end

        // R4: closed bank stays silent for all-zero and all-one rows.
        drive(0, 0, 0, 2'd0, 13'h0000);
        #1; check("R4", 1'b0, 1'b0);
        drive(0, 0, 0, 2'd0, 13'h1FFF);
        #1; check("R4", 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run = hung, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule